// File: doc/BRIEF.md
# Late-Collision Statistics Counter

This block is a memory-mapped statistics register that counts late collisions. A transmit MAC raises a one-cycle pulse on `collisionEvent` each time it sees a collision after a frame has started to go out. The register adds one to a 16-bit count for each pulse. The count saturates at its top value and never wraps. The count sits in the low half of a 32-bit register word, and the upper half always reads as zero.

Software reaches the register through a simple slave port made of a select, a read strobe, a write strobe and 32-bit write and read data. A mode input picks one of two ways for software to clear the count:

- **Clear-on-read (mode 1):** a selected read returns the count and then resets it.
- **Key write (mode 0):** only a selected write of a fixed 32-bit key resets the count.

An event that arrives in the same cycle as a clear is never lost. Read data is registered and is presented one cycle after the read strobe.

Top module: `lateCollisionCounter`

## Requirements
- R1: After reset, the count is zero and `rdData` is zero.
- R2: Each cycle with `collisionEvent` high, with no clear in that cycle and the count below 0xFFFF, increments the count by exactly one.
- R3: Once the count reaches 0xFFFF, further events leave it at 0xFFFF until a clear occurs.
- R4: Bits 31 to 16 of `rdData` always read as zero, whatever value was written to them.
- R5: With `clearOnRead`=1, a cycle with `regSel`=1 and `rdStrobe`=1 puts the count held before that edge on `rdData[15:0]` one cycle later. In that same edge the count is reset to zero.
- R6: With `clearOnRead`=0, a selected read returns the count one cycle later and leaves the count unchanged.
- R7: With `clearOnRead`=0, a cycle with `regSel`=1, `wrStrobe`=1 and `wrData`=0x11111111 resets the count to zero.
- R8: A selected write has no effect on the count in two cases. The first is any value other than 0x11111111 while `clearOnRead`=0. The second is any value, including 0x11111111, while `clearOnRead`=1.
- R9: When an event coincides with a clear (from either R5 or R7), the count becomes 1 after that edge.
- R10: A read or write strobe with `regSel`=0 neither changes the count nor updates `rdData`. `rdData` holds its value in every cycle without a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| collisionEvent | input | 1 | One-cycle late-collision pulse from the MAC |
| clearOnRead | input | 1 | 1: a selected read clears; 0: a selected key write clears |
| regSel | input | 1 | This register is addressed this cycle |
| rdStrobe | input | 1 | Read strobe |
| wrStrobe | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data; the count is in bits 15:0 |

## Verification
The hardest situation to reach is a clear or an event while the count is saturated at 0xFFFF. It takes 65535 events to get there. The bench drives one continuous run of events, reads the count back at the ceiling, keeps driving events past it, and then clears the count in the same cycle as a final event. Event-and-clear collisions are also swept for both clear modes at small counts. A set of near-key write values, each differing from the key by one bit, is applied to show that only the exact key clears the count.

// File: rtl/lcCountPkg.sv
package lcCountPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic inc;      // add an event this cycle
    logic clr;      // reset count this cycle
    logic capture;  // load read data register
  } ctlStrobes_t;
endpackage

// File: rtl/lcCountCtl.sv
module lcCountCtl
  import lcCountPkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CLEAR_KEY = 32'h1111_1111
) (
  input  logic              collisionEvent,
  input  logic              clearOnRead,
  input  logic              regSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              countAtMax,
  output ctlStrobes_t       strb
);
  logic rdHit;
  logic wrHit;
  logic keyMatch;
  logic clrReq;

  assign rdHit    = regSel & rdStrobe;
  assign wrHit    = regSel & wrStrobe;
  assign keyMatch = (wrData == CLEAR_KEY);

  always_comb begin
    if (clearOnRead) clrReq = rdHit;
    else             clrReq = wrHit & keyMatch;
  end

  always_comb begin
    strb.clr     = clrReq;
    // after a clear the event is the first count; otherwise stop at max
    strb.inc     = collisionEvent & (clrReq | ~countAtMax);
    strb.capture = rdHit;
  end
endmodule

// File: rtl/lcCountDp.sv
module lcCountDp
  import lcCountPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  output logic [CNT_W-1:0]  countQ,
  output logic              countAtMax,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.clr) begin
      countQ <= strb.inc ? ONE : '0;
    end else if (strb.inc) begin
      countQ <= countQ + ONE;
    end
  end

  assign countAtMax = &countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.capture) begin
      rdData <= {{PAD_W{1'b0}}, countQ};
    end
  end
endmodule

// File: rtl/lateCollisionCounter.sv
module lateCollisionCounter
  import lcCountPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CLEAR_KEY = 32'h1111_1111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              collisionEvent,
  input  logic              clearOnRead,
  input  logic              regSel,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  ctlStrobes_t      strb;
  logic [CNT_W-1:0] countQ;
  logic             countAtMax;

  lcCountCtl #(.DATA_W(DATA_W), .CLEAR_KEY(CLEAR_KEY)) u_ctl (
    .collisionEvent(collisionEvent),
    .clearOnRead   (clearOnRead),
    .regSel        (regSel),
    .rdStrobe      (rdStrobe),
    .wrStrobe      (wrStrobe),
    .wrData        (wrData),
    .countAtMax    (countAtMax),
    .strb          (strb)
  );

  lcCountDp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .countQ    (countQ),
    .countAtMax(countAtMax),
    .rdData    (rdData)
  );
endmodule

// File: rtl/lateCollisionCounterChecker.sv
module lateCollisionCounterChecker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CLEAR_KEY = 32'h1111_1111
) (
  input logic              clk,
  input logic              rstN,
  input logic              collisionEvent,
  input logic              clearOnRead,
  input logic              regSel,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [CNT_W-1:0]  countQ
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic selRd;
  logic clrSeen;
  assign selRd   = regSel & rdStrobe;
  assign clrSeen = clearOnRead ? selRd
                               : (regSel & wrStrobe & (wrData == CLEAR_KEY));

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rstN)
    (collisionEvent && !clrSeen && countQ != MAXV) |=> countQ == $past(countQ) + ONE);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == MAXV && !clrSeen) |=> countQ == MAXV);

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:CNT_W] == '0);

  assert_read_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    selRd |=> rdData[CNT_W-1:0] == $past(countQ));

  assert_clear_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrSeen && collisionEvent) |=> countQ == ONE);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !selRd |=> $stable(rdData));

  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!collisionEvent && !clrSeen) |=> $stable(countQ));
endmodule

bind lateCollisionCounter lateCollisionCounterChecker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .CLEAR_KEY(CLEAR_KEY)
) u_checker (
  .clk(clk), .rstN(rstN), .collisionEvent(collisionEvent),
  .clearOnRead(clearOnRead), .regSel(regSel), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .wrData(wrData), .rdData(rdData), .countQ(countQ)
);

// File: tb/lateCollisionCounter_bench.sv
module lateCollisionCounter_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1111_1111;

  logic        clk = 1'b0;
  logic        rstN;
  logic        collisionEvent;
  logic        clearOnRead;
  logic        regSel;
  logic        rdStrobe;
  logic        wrStrobe;
  logic [31:0] wrData;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] expCount;
  logic [31:0] expRd;

  always #(PERIOD/2) clk = ~clk;

  lateCollisionCounter u_lateCollisionCounter (
    .clk(clk), .rstN(rstN), .collisionEvent(collisionEvent),
    .clearOnRead(clearOnRead), .regSel(regSel), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive, advance to next falling edge, update model, check rdData
  task automatic cyc(input string tag, input logic ev, input logic sel,
                     input logic rd, input logic wr, input logic [31:0] d);
    logic clr;
    collisionEvent = ev; regSel = sel; rdStrobe = rd; wrStrobe = wr; wrData = d;
    @(negedge clk);
    clr = clearOnRead ? (sel && rd) : (sel && wr && d == KEY);
    if (sel && rd) expRd = {16'h0, expCount};
    if (clr)                       expCount = ev ? 16'd1 : 16'd0;
    else if (ev && expCount != 16'hFFFF) expCount = expCount + 16'd1;
    check(tag, rdData, expRd);
    collisionEvent = 0; regSel = 0; rdStrobe = 0; wrStrobe = 0; wrData = '0;
  endtask

  // read and compare against the model (rdData checked inside cyc)
  task automatic readBack(input string tag);
    cyc(tag, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; collisionEvent = 0; clearOnRead = 0; regSel = 0;
    rdStrobe = 0; wrStrobe = 0; wrData = '0;
    expCount = 0; expRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1 reset rdData", rdData, 32'h0);
    readBack("R1 reset count");

    // R2/R6/R5: sweep event counts and gap patterns in both modes
    for (int mode = 0; mode < 2; mode++) begin
      clearOnRead = mode[0];
      for (int n = 0; n < 24; n++) begin
        for (int k = 0; k < n; k++) begin
          cyc("R2 event", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
          if ((k % 3) == 2) cyc("R10 idle gap", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        end
        readBack(mode ? "R5 clear-on-read value" : "R6 read keeps count");
        readBack(mode ? "R5 read after clear" : "R6 second read");
        if (!mode) cyc("R7 key write", 1'b0, 1'b1, 1'b0, 1'b1, KEY);
        readBack("R7 after clear");
      end
    end

    // R8: near-key and other writes in mode 0, all writes in mode 1
    clearOnRead = 0;
    repeat (5) cyc("R2 load", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    for (int b = 0; b < 32; b++)
      cyc("R8 near-key write", 1'b0, 1'b1, 1'b0, 1'b1, KEY ^ (32'h1 << b));
    cyc("R8 ones write", 1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    cyc("R4 upper write", 1'b0, 1'b1, 1'b0, 1'b1, 32'hABCD_0000);
    readBack("R8 mode0 count kept");
    readBack("R4 upper zero");
    clearOnRead = 1;
    cyc("R8 key ignored mode1", 1'b0, 1'b1, 1'b0, 1'b1, KEY);
    cyc("R8 zero write mode1", 1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    clearOnRead = 0;
    readBack("R8 mode1 count kept");

    // R10: unselected strobes
    clearOnRead = 1;
    cyc("R10 unselected read", 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    clearOnRead = 0;
    cyc("R10 unselected key", 1'b0, 1'b0, 1'b0, 1'b1, KEY);
    readBack("R10 count kept");

    // R9: event coinciding with clears in each mode
    cyc("R9 key+event", 1'b1, 1'b1, 1'b0, 1'b1, KEY);
    readBack("R9 mode0 result one");
    clearOnRead = 1;
    cyc("R2 load", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R9 read+event", 1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
    readBack("R9 mode1 result one");

    // R3: saturate
    clearOnRead = 0;
    for (int k = 0; k < 65540; k++) cyc("R3 fill", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    readBack("R3 saturated");
    for (int k = 0; k < 8; k++) cyc("R3 past max", 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    readBack("R3 still saturated");
    cyc("R9 key+event at max", 1'b1, 1'b1, 1'b0, 1'b1, KEY);
    readBack("R9 one after max clear");
    clearOnRead = 1;
    readBack("R5 final clear");
    readBack("R5 zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule